// File: doc/BRIEF.md
# Word-Oriented SPI Master With Register Interface

This block is a serial peripheral interface master controlled through eight 16-bit registers on a simple synchronous bus. Software sets the serial clock rate, the sampling edge and the interrupt behaviour, loads a transmit word, and then issues a write command, a read command or both. Each command moves one word of a programmed length. The block drives the serial clock, the data output and two active-low chip selects, and it samples the serial data input.

Each direction has its own done flag in a status register. The flags can feed two interrupt outputs, whose polarity and level or pulse signalling are programmable. A command issued while the serial clock is disabled stays queued until the clock is enabled. A write always runs before a read when both are requested together. Words of eight bits or fewer are sent as 16-bit frames, so a byte placed in the top of the upper transmit halfword goes out first.

Top module: `spi_word_master`

## Requirements
- R1: Registers sit at byte offsets 0x0 CFG, 0x2 MODE, 0x4 CMD, 0x6 FLAGS, 0x8 TX_LO, 0xA TX_HI, 0xC RX_LO and 0xE RX_HI, and all read zero after reset. After reset cs_n is 2'b11, sclk is 0, and both interrupt outputs are high, which is inactive because the polarity bit resets to 0.
- R2: CFG bit 0 enables the serial clock. While it is 0, no transfer starts, sclk holds its level, and a queued command waits until the bit is set.
- R3: CMD bits [6:2] hold the word length minus one. Codes 0 to 7 produce a 16-bit frame, and codes 8 to 31 produce frames of 9 to 32 bits. A frame has exactly that many sampling edges.
- R4: A write sends the word {TX_HI,TX_LO} starting at bit 31 and going downward, so the frame is left-aligned and MSB first. During a read, mosi stays 0.
- R5: A read shifts miso in MSB first and stores the word right-aligned in {RX_HI,RX_LO}, with the bits above the frame length cleared. The RX registers change only when a read completes.
- R6: MODE bit 0 selects the sampling edge: 1 samples on the rising edge and 0 samples on the falling edge. sclk idles low, and mosi changes only at bit boundaries.
- R7: CMD bit 7 selects the chip select: 0 drives cs_n[0] low and 1 drives cs_n[1] low. The selected line is low only while a frame runs, and at most one line is low at any time.
- R8: FLAGS bit 1 sets when a write completes and bit 0 sets when a read completes. Writing 0 to a flag bit clears that flag, and writing 1 leaves it unchanged. A new write command (CMD bit 1) or read command (CMD bit 0) clears its own flag.
- R9: When CMD bits 1 and 0 are both set, the write frame runs first and the read frame runs second, each as a separate chip-select period.
- R10: CFG bit 4 enables irq_wr and CFG bit 5 enables irq_rd. Each interrupt is active while its enable and its flag are both set. MODE bit 5 selects active-high (1) or active-low (0) outputs. MODE bit 10 selects a one-cycle pulse on the rising edge of the condition (1) or the plain level (0).
- R11: CFG bits [3:1] hold a rate code d. Each sclk half-period lasts 4^d clock cycles, so a frame of N bits keeps its chip select low for 2*N*4^d cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational on the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 2 | Active-low chip selects |
| miso | input | 1 | Serial data in |
| irq_wr | output | 1 | Write-complete interrupt |
| irq_rd | output | 1 | Read-complete interrupt |

## Verification
A wrong bit counter or a wrong length decode shows at the ports as the wrong number of sampling edges. The bench counts those edges per chip-select period, and the error is visible as soon as the frame ends. A broken rate counter shows as a chip-select period of the wrong length. A broken shift path or a wrong sampling edge corrupts the captured or returned word within that same frame. Queueing and ordering faults appear one frame later, as a transfer that starts while the clock is disabled or as a read period that comes before the write period.

// File: rtl/spi_word_master.sv
module spi_word_master #(
  parameter int DIV_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_we,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  output logic [1:0]  cs_n,
  input  logic        miso,
  output logic        irq_wr,
  output logic        irq_rd
);
  localparam int CNT_W = 2 * ((1 << DIV_W) - 1) + 1;

  logic             r_en, r_ie_wr, r_ie_rd, r_edge, r_pol, r_trig, r_csel;
  logic [DIV_W-1:0] r_div;
  logic [4:0]       r_len;
  logic [31:0]      r_tx, r_rx, sr_tx, sr_rx;
  logic             st_wr, st_rd, pend_wr, pend_rd;
  logic             busy, half, is_rd, cur_cs;
  logic [5:0]       bits;
  logic [CNT_W-1:0] cnt;
  logic             raw_wq, raw_rq;

  wire we_cfg  = bus_we && bus_addr[3:1] == 3'd0;
  wire we_mode = bus_we && bus_addr[3:1] == 3'd1;
  wire we_cmd  = bus_we && bus_addr[3:1] == 3'd2;
  wire we_flag = bus_we && bus_addr[3:1] == 3'd3;
  wire we_txl  = bus_we && bus_addr[3:1] == 3'd4;
  wire we_txh  = bus_we && bus_addr[3:1] == 3'd5;

  wire [5:0]       eff_len = (r_len <= 5'd7) ? 6'd16 : {1'b0, r_len} + 6'd1;
  wire [CNT_W-1:0] lim_m1  = (CNT_W'(1) << {r_div, 1'b0}) - CNT_W'(1);
  wire             start   = !busy && r_en && (pend_wr || pend_rd);
  wire             tick    = busy && r_en && cnt == lim_m1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_en <= 1'b0; r_ie_wr <= 1'b0; r_ie_rd <= 1'b0; r_div <= '0;
      r_edge <= 1'b0; r_pol <= 1'b0; r_trig <= 1'b0;
      r_len <= '0; r_csel <= 1'b0; r_tx <= '0; r_rx <= '0;
      st_wr <= 1'b0; st_rd <= 1'b0; pend_wr <= 1'b0; pend_rd <= 1'b0;
      busy <= 1'b0; half <= 1'b0; is_rd <= 1'b0; cur_cs <= 1'b0;
      bits <= '0; cnt <= '0; sr_tx <= '0; sr_rx <= '0;
      raw_wq <= 1'b0; raw_rq <= 1'b0;
    end else begin
      if (we_cfg) begin
        r_en <= bus_wdata[0]; r_div <= bus_wdata[DIV_W:1];
        r_ie_wr <= bus_wdata[4]; r_ie_rd <= bus_wdata[5];
      end
      if (we_mode) begin
        r_edge <= bus_wdata[0]; r_pol <= bus_wdata[5]; r_trig <= bus_wdata[10];
      end
      if (we_cmd) begin
        r_len <= bus_wdata[6:2]; r_csel <= bus_wdata[7];
      end
      if (we_txl) r_tx[15:0]  <= bus_wdata;
      if (we_txh) r_tx[31:16] <= bus_wdata;

      if (start) begin
        if (pend_wr) pend_wr <= 1'b0;
        else         pend_rd <= 1'b0;
      end
      if (we_cmd && bus_wdata[1]) pend_wr <= 1'b1;
      if (we_cmd && bus_wdata[0]) pend_rd <= 1'b1;

      if (we_flag) begin
        st_wr <= st_wr & bus_wdata[1];
        st_rd <= st_rd & bus_wdata[0];
      end
      if (we_cmd && bus_wdata[1]) st_wr <= 1'b0;
      if (we_cmd && bus_wdata[0]) st_rd <= 1'b0;

      if (start) begin
        busy <= 1'b1; half <= 1'b0; cnt <= '0; is_rd <= !pend_wr;
        cur_cs <= r_csel; bits <= eff_len; sr_tx <= r_tx; sr_rx <= '0;
      end else if (busy && r_en) begin
        if (!tick) cnt <= cnt + CNT_W'(1);
        else begin
          cnt <= '0;
          if (!half) begin
            half <= 1'b1;
            if (is_rd) sr_rx <= {sr_rx[30:0], miso};
          end else begin
            half <= 1'b0;
            if (bits == 6'd1) begin
              busy <= 1'b0;
              if (is_rd) begin st_rd <= 1'b1; r_rx <= sr_rx; end
              else st_wr <= 1'b1;
            end else begin
              bits  <= bits - 6'd1;
              sr_tx <= {sr_tx[30:0], 1'b0};
            end
          end
        end
      end

      raw_wq <= r_ie_wr && st_wr;
      raw_rq <= r_ie_rd && st_rd;
    end
  end

  assign sclk  = busy && (half ~^ r_edge);
  assign mosi  = busy && !is_rd && sr_tx[31];
  assign cs_n  = {!(busy && cur_cs), !(busy && !cur_cs)};

  wire raw_w = r_ie_wr && st_wr;
  wire raw_r = r_ie_rd && st_rd;
  wire act_w = r_trig ? raw_w && !raw_wq : raw_w;
  wire act_r = r_trig ? raw_r && !raw_rq : raw_r;
  assign irq_wr = r_pol ? act_w : !act_w;
  assign irq_rd = r_pol ? act_r : !act_r;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr[3:1])
      3'd0: begin
        bus_rdata[0] = r_en; bus_rdata[DIV_W:1] = r_div;
        bus_rdata[4] = r_ie_wr; bus_rdata[5] = r_ie_rd;
      end
      3'd1: begin
        bus_rdata[0] = r_edge; bus_rdata[5] = r_pol; bus_rdata[10] = r_trig;
      end
      3'd2: bus_rdata = {8'd0, r_csel, r_len, 2'b00};
      3'd3: bus_rdata = {14'd0, st_wr, st_rd};
      3'd4: bus_rdata = r_tx[15:0];
      3'd5: bus_rdata = r_tx[31:16];
      3'd6: bus_rdata = r_rx[15:0];
      default: bus_rdata = r_rx[31:16];
    endcase
  end

  assert_hold_while_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !r_en) |=> !busy);

  assert_sclk_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !r_en && !we_mode) |=> $stable(sclk));

  assert_single_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_rd_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_rd) |-> $past(busy && is_rd));

  assert_wr_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_wr) |-> $past(busy && !is_rd));

  assert_pulse_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (r_trig && irq_rd == r_pol) |=> (!r_trig || !$stable(r_pol) || irq_rd != r_pol));
endmodule

// File: tb/test_spi_word_master.sv
module test_spi_word_master;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sclk, mosi, miso, irq_wr, irq_rd;
  logic [1:0]  cs_n;

  spi_word_master i_spi_word_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .miso(miso), .irq_wr(irq_wr), .irq_rd(irq_rd)
  );

  // slave model
  logic        act_lvl = 1'b1;
  int          slen = 16;
  logic [31:0] pat = '0;
  int          idx = 0;
  logic [31:0] cap = '0;
  logic [1:0]  prev_cs = 2'b11;
  logic        prev_sclk = 1'b0;
  int          nsess = 0;
  logic [31:0] sess_cap [8];
  int          sess_edges [8];
  logic [1:0]  sess_cs [8];

  assign miso = (idx < slen) ? pat[slen-1-idx] : 1'b0;

  always @(sclk or cs_n) begin
    if (&cs_n) begin
      if (!(&prev_cs)) begin
        sess_cap[nsess%8] = cap; sess_edges[nsess%8] = idx;
        sess_cs[nsess%8] = prev_cs; nsess = nsess + 1;
      end
      cap = '0; idx = 0;
    end else if (sclk !== prev_sclk && sclk === act_lvl) begin
      cap = {cap[30:0], mosi}; idx = idx + 1;
    end
    prev_cs = cs_n; prev_sclk = sclk;
  end

  int run = 0, last_run = 0;
  always @(negedge clk) begin
    if (!(&cs_n)) run = run + 1;
    else begin
      if (run != 0) last_run = run;
      run = 0;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_done(input logic [1:0] m, input string tag);
    logic [15:0] s;
    bit ok = 0;
    for (int i = 0; i < 20000; i++) begin
      rd(4'h6, s);
      if ((s[1:0] & m) == m) begin ok = 1; break; end
    end
    if (!ok) chk({tag, " completion"}, {30'd0, s[1:0]}, {30'd0, m});
    repeat (2) @(negedge clk);
  endtask

  function automatic int eff_of(input logic [4:0] c);
    return (c <= 5'd7) ? 16 : int'(c) + 1;
  endfunction

  function automatic logic [31:0] mask_of(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  typedef struct packed {
    logic        e;
    logic [4:0]  code;
    logic        rd;
    logic        cs;
    logic [2:0]  div;
    logic [31:0] tx;
    logic [31:0] pat;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{1'b1, 5'd15, 1'b0, 1'b0, 3'd0, 32'hA5C3_0000, 32'h0},
    '{1'b0, 5'd7,  1'b0, 1'b1, 3'd0, 32'h5A00_0000, 32'h0},
    '{1'b1, 5'd31, 1'b0, 1'b0, 3'd1, 32'hDEAD_BEEF, 32'h0},
    '{1'b1, 5'd11, 1'b1, 1'b0, 3'd0, 32'h0, 32'hFFFF_FABC},
    '{1'b0, 5'd23, 1'b1, 1'b1, 3'd1, 32'h0, 32'h0012_3456},
    '{1'b1, 5'd2,  1'b1, 1'b0, 3'd0, 32'h0, 32'h0000_F00F},
    '{1'b0, 5'd31, 1'b1, 1'b1, 3'd0, 32'h0, 32'h89AB_CDEF},
    '{1'b1, 5'd8,  1'b0, 1'b0, 3'd0, 32'hFF80_0000, 32'h0}
  };

  task automatic run_vec(input int k);
    vec_t v;
    int e, s0, sl;
    logic [15:0] lo, hi;
    v = VEC[k];
    e = eff_of(v.code);
    wr(4'h6, 16'h0);
    wr(4'h0, {12'd0, v.div, 1'b1});
    wr(4'h2, {15'd0, v.e});
    wr(4'h8, v.tx[15:0]);
    wr(4'hA, v.tx[31:16]);
    act_lvl = v.e; slen = e; pat = v.pat; s0 = nsess;
    wr(4'h4, {8'd0, v.cs, v.code, !v.rd, v.rd});
    wait_done(v.rd ? 2'b01 : 2'b10, $sformatf("R8 vec%0d", k));
    sl = s0 % 8;
    chk($sformatf("R3 vec%0d sampling edges", k), sess_edges[sl], e);
    chk($sformatf("R7 vec%0d chip select", k), {30'd0, sess_cs[sl]}, v.cs ? 32'd1 : 32'd2);
    chk($sformatf("R11 vec%0d select low cycles", k), last_run, 2 * e * (4 ** v.div));
    if (!v.rd) begin
      chk($sformatf("R4 R6 vec%0d mosi word", k), sess_cap[sl], v.tx >> (32 - e));
    end else begin
      rd(4'hC, lo); rd(4'hE, hi);
      chk($sformatf("R5 R6 vec%0d rx word", k), {hi, lo}, v.pat & mask_of(e));
      chk($sformatf("R4 vec%0d mosi low on read", k), sess_cap[sl], 32'h0);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] s, lo, hi;
    int s0, pulses;
    bit seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 16; a += 2) begin
      rd(4'(a), s);
      chk($sformatf("R1 reset reg 0x%0h", a), {16'd0, s}, 32'h0);
    end
    chk("R1 reset outputs", {26'd0, cs_n, sclk, irq_wr, irq_rd, 1'b0}, {26'd0, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0});

    for (int k = 0; k < 8; k++) run_vec(k);

    // R8 per-bit clear
    wr(4'h6, 16'h0); act_lvl = 1'b1; wr(4'h2, 16'h0001);
    wr(4'h4, {8'd0, 1'b0, 5'd15, 2'b11});
    wait_done(2'b11, "R8 setup");
    wr(4'h6, 16'h0002); rd(4'h6, s);
    chk("R8 write 0 clears only that flag", {16'd0, s}, 32'h2);
    wr(4'h6, 16'h0000); rd(4'h6, s);
    chk("R8 write 0 clears flags", {16'd0, s}, 32'h0);

    // R2 hold while clock disabled
    wr(4'h0, 16'h0000); wr(4'h8, 16'h0); wr(4'hA, 16'h1234);
    s0 = nsess;
    wr(4'h4, {8'd0, 1'b0, 5'd15, 2'b10});
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cs_n != 2'b11 || sclk) seen = 1;
    end
    chk("R2 no activity while disabled", {31'd0, seen}, 32'h0);
    rd(4'h6, s);
    chk("R2 no flag while disabled", {16'd0, s}, 32'h0);
    wr(4'h0, 16'h0001);
    wait_done(2'b10, "R2 resume");
    chk("R2 queued write runs after enable", sess_cap[s0%8], 32'h1234);

    // R8 new command clears its flag
    wr(4'h0, 16'h0000);
    wr(4'h4, {8'd0, 1'b0, 5'd15, 2'b10});
    rd(4'h6, s);
    chk("R8 new write clears write flag", {16'd0, s}, 32'h0);
    wr(4'h0, 16'h0001);
    wait_done(2'b10, "R8 rerun");

    // R9 write before read
    wr(4'h6, 16'h0); wr(4'h8, 16'h0); wr(4'hA, 16'hC3C3);
    pat = 32'h0000_5A5A; slen = 16; s0 = nsess;
    wr(4'h4, {8'd0, 1'b1, 5'd15, 2'b11});
    wait_done(2'b11, "R9 both");
    chk("R9 two select periods", nsess - s0, 2);
    chk("R9 first period is the write", sess_cap[s0%8], 32'hC3C3);
    chk("R9 second period is the read", sess_cap[(s0+1)%8], 32'h0);
    rd(4'hC, lo); rd(4'hE, hi);
    chk("R9 read data", {hi, lo}, 32'h5A5A);

    // R10 level, active high
    wr(4'h6, 16'h0); wr(4'h2, 16'h0021); wr(4'h0, 16'h0011);
    chk("R10 idle active-high outputs", {30'd0, irq_wr, irq_rd}, 32'h0);
    wr(4'h4, {8'd0, 1'b0, 5'd15, 2'b10});
    wait_done(2'b10, "R10 level");
    chk("R10 level write irq asserted", {30'd0, irq_wr, irq_rd}, 32'h2);
    wr(4'h6, 16'h0);
    chk("R10 level irq drops on clear", {31'd0, irq_wr}, 32'h0);

    // R10 pulse mode
    wr(4'h2, 16'h0421); wr(4'h0, 16'h0021);
    pulses = 0;
    wr(4'h4, {8'd0, 1'b0, 5'd15, 2'b01});
    for (int i = 0; i < 5000; i++) begin
      rd(4'h6, s);
      if (irq_rd) pulses++;
      if (s[0]) break;
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (irq_rd) pulses++;
    end
    chk("R10 pulse lasts one cycle", pulses, 1);
    rd(4'h6, s);
    chk("R10 flag stays after pulse", {16'd0, s}, 32'h1);

    // R10 enable off
    wr(4'h2, 16'h0020); wr(4'h0, 16'h0001);
    chk("R10 disabled irq stays inactive", {30'd0, irq_wr, irq_rd}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule